// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog peripheral behind a simple byte-addressed register port with a 64-byte window. Software programs two preload values, one for each stage, a configuration byte and an enable/lock byte. A down counter then runs from the first preload. When it runs out, the block raises a latched timeout flag and reloads from the second preload. When the second stage runs out, the block can request a system reset of a selected kind (warm or cold) and can toggle a timeout pin. After that it starts over from the first stage.

The preload registers and the reload/flag-clear control byte are guarded. A write to any of them takes effect only if it comes directly after the two key bytes 0x80 and 0x86, written to the key offset. Each protected write uses up the unlock. A sticky lock bit freezes the enable bit and the configuration. Only a block reset clears the lock.

A preload value can be placed at the top of the counter, above a parameterised prescale of `SHIFT` bits, or at its bottom. The configuration byte makes that choice. Software programs one less than the number of periods it wants.

Top module: `keyed_wdt`

## Requirements
- R1: After reset all outputs are low, the unlock state is idle, and reads of offsets 0x00, 0x04, 0x10, 0x14 and 0x18 return 0.
- R2: Writing 0x80 and then 0x86 to the key byte at offset 0x0C (data in wdata[7:0]) lets exactly one following write to offset 0x00 (stage-one preload), 0x04 (stage-two preload) or 0x0D (control byte) take effect. A second protected write without a new key pair is dropped.
- R3: A protected write is dropped when no key pair came before it, when the second key byte is not 0x86, or when any other register write comes between the key pair and the protected write. That other write still acts on its own register.
- R4: A guarded write to offset 0x0D with bit 0 set loads the counter from the stage-one preload and returns to stage one in the cycle after the write. With bit 1 set, it clears the timeout flag.
- R5: Configuration bit 2 (prescale) set loads preload P as P shifted left by SHIFT with the low SHIFT bits all ones, so a stage lasts (P+1)·2^SHIFT clocks. With bit 2 clear, the counter loads P and a stage lasts P+1 clocks.
- R6: When stage one runs out, stage1_flag goes high and stays high. The counter reloads from the stage-two preload and keeps counting.
- R7: When stage two runs out, rst_req is high for one cycle if configuration bit 4 is set. rst_warm then equals configuration bit 3 (1 = warm). The counter restarts from the stage-one preload in stage one.
- R8: When stage two runs out, tout_pin toggles unless configuration bit 5 is set.
- R9: Offset 0x18 holds bit 1 = enable and bit 0 = lock. Turning enable from 0 to 1 loads the stage-one preload. Writing enable as 1 while it is already 1 does not reload. While enable is 0 the counter holds its value.
- R10: Once lock is set it stays set until reset. While it is set, writes to offsets 0x18 and 0x10 are ignored.
- R11: A read of offset 0x14 returns the counter shifted right by max(width-32, 0). Offsets 0x00 and 0x04 read back the preloads. Offset 0x10 reads back the configuration byte, keeping only bits 2 to 5.
- R12: If a guarded reload lands in the same cycle as an expiry, the reload decides the counter and the stage. The expiry still sets the flag, and a flag clear in that cycle loses to the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 6 | Write byte offset |
| wdata | input | 32 | Write data; byte registers use bits 7:0 |
| rd_addr | input | 6 | Read byte offset |
| rdata | output | 32 | Combinational read data |
| stage1_flag | output | 1 | Latched stage-one timeout flag |
| rst_req | output | 1 | One-cycle reset request after stage two |
| rst_warm | output | 1 | Kind of the last reset request, 1 = warm |
| tout_pin | output | 1 | Timeout pin, toggles after stage two |

## Verification
A guarded reload and a stage-one expiry can fall in the same cycle. The bench enables the timer with a stage-one preload of 2, then writes the two key bytes and the control byte on back-to-back cycles, so the control write lands on the expiry edge. The result is judged on three points. The flag must be set even though the same write asks to clear it. The counter read must show the stage-one load value. No reset request may appear when a wrongly entered stage two would have run out.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_PRE_A = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PRE_B = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 6'h0D;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_GUARD = 6'h18;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  localparam int CFG_SCALE  = 2;
  localparam int CFG_WARM   = 3;
  localparam int CFG_RSTEN  = 4;
  localparam int CFG_NOTOG  = 5;
  localparam logic [7:0] CFG_MASK = 8'h3C;

  typedef enum logic [1:0] {UK_IDLE, UK_HALF, UK_OPEN} ukey_t;
endpackage

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [PRE_W-1:0]  pre_a,
  output logic [PRE_W-1:0]  pre_b,
  output logic [7:0]        cfg,
  output logic              enable,
  output logic              lock,
  output logic              reload_pulse,
  output logic              clear_pulse,
  output logic              start_pulse
);
  ukey_t ukey;

  // named events for the checks
  logic key_hit, prot_tgt, prot_ok, guard_wr, cfg_wr;

  always_comb begin
    key_hit  = wr_en && (addr == OFS_KEY);
    prot_tgt = wr_en && ((addr == OFS_PRE_A) || (addr == OFS_PRE_B) || (addr == OFS_CTL));
    prot_ok  = prot_tgt && (ukey == UK_OPEN);
    guard_wr = wr_en && (addr == OFS_GUARD) && !lock;
    cfg_wr   = wr_en && (addr == OFS_CFG) && !lock;
    reload_pulse = prot_ok && (addr == OFS_CTL) && wdata[0];
    clear_pulse  = prot_ok && (addr == OFS_CTL) && wdata[1];
    start_pulse  = guard_wr && wdata[1] && !enable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ukey <= UK_IDLE;
    end else if (wr_en) begin
      if (key_hit && wdata[7:0] == KEY_FIRST)
        ukey <= UK_HALF;
      else if (key_hit && ukey == UK_HALF && wdata[7:0] == KEY_SECOND)
        ukey <= UK_OPEN;
      else
        ukey <= UK_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_a  <= '0;
      pre_b  <= '0;
      cfg    <= '0;
      enable <= 1'b0;
      lock   <= 1'b0;
    end else begin
      if (prot_ok && addr == OFS_PRE_A) pre_a <= wdata[PRE_W-1:0];
      if (prot_ok && addr == OFS_PRE_B) pre_b <= wdata[PRE_W-1:0];
      if (cfg_wr) cfg <= wdata[7:0] & CFG_MASK;
      if (guard_wr) begin
        enable <= wdata[1];
        lock   <= wdata[0];
      end
    end
  end

  assert_preload_keyed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pre_a) || !$stable(pre_b)) |-> $past(ukey == UK_OPEN));
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  assert_locked_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(enable));
  assert_locked_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cfg));
endmodule

// File: rtl/kwdt_stager.sv
module kwdt_stager
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int SHIFT = 15,
  localparam int CNT_W = PRE_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] pre_a,
  input  logic [PRE_W-1:0] pre_b,
  input  logic [7:0]       cfg,
  input  logic             reload_pulse,
  input  logic             clear_pulse,
  input  logic             start_pulse,
  output logic [CNT_W-1:0] cnt,
  output logic             stage1_flag,
  output logic             rst_req,
  output logic             rst_warm,
  output logic             tout_pin
);
  localparam logic [CNT_W-1:0] LOW_ONES = (CNT_W'(1) << SHIFT) - CNT_W'(1);

  // placement of a preload in the counter, see R5
  function automatic logic [CNT_W-1:0] load_value(input logic [PRE_W-1:0] p,
                                                   input logic scaled);
    if (scaled) return (CNT_W'(p) << SHIFT) | LOW_ONES;
    return CNT_W'(p);
  endfunction

  logic in_b;
  logic load_req, at_zero, exp_a, exp_b;

  always_comb begin
    load_req = reload_pulse || start_pulse;
    at_zero  = (cnt == '0);
    exp_a    = enable && at_zero && !in_b;
    exp_b    = enable && at_zero && in_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      in_b <= 1'b0;
    end else if (load_req) begin
      cnt  <= load_value(pre_a, cfg[CFG_SCALE]);
      in_b <= 1'b0;
    end else if (exp_a) begin
      cnt  <= load_value(pre_b, cfg[CFG_SCALE]);
      in_b <= 1'b1;
    end else if (exp_b) begin
      cnt  <= load_value(pre_a, cfg[CFG_SCALE]);
      in_b <= 1'b0;
    end else if (enable) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_flag <= 1'b0;
      rst_req     <= 1'b0;
      rst_warm    <= 1'b0;
      tout_pin    <= 1'b0;
    end else begin
      if (exp_a) stage1_flag <= 1'b1;
      else if (clear_pulse) stage1_flag <= 1'b0;
      rst_req <= exp_b && cfg[CFG_RSTEN];
      if (exp_b) rst_warm <= cfg[CFG_WARM];
      tout_pin <= tout_pin ^ (exp_b && !cfg[CFG_NOTOG]);
    end
  end

  assert_flag_from_stage1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage1_flag) |-> $past(exp_a));
  assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_req_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_warm == $past(cfg[CFG_WARM])));
  assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load_req) |=> $stable(cnt));
  assert_reload_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> (!in_b && cnt == $past(load_value(pre_a, cfg[CFG_SCALE]))));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int SHIFT = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  input  logic [5:0]  rd_addr,
  output logic [31:0] rdata,
  output logic        stage1_flag,
  output logic        rst_req,
  output logic        rst_warm,
  output logic        tout_pin
);
  localparam int CNT_W = PRE_W + SHIFT;
  localparam int RD_SH = (CNT_W > 32) ? CNT_W - 32 : 0;

  function automatic logic [31:0] count_view(input logic [CNT_W-1:0] c);
    return 32'(c >> RD_SH);
  endfunction

  logic [PRE_W-1:0] pre_a, pre_b;
  logic [7:0]       cfg;
  logic             enable, lock;
  logic             reload_pulse, clear_pulse, start_pulse;
  logic [CNT_W-1:0] cnt;

  kwdt_keygate #(.PRE_W(PRE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pre_a(pre_a), .pre_b(pre_b), .cfg(cfg), .enable(enable), .lock(lock),
    .reload_pulse(reload_pulse), .clear_pulse(clear_pulse),
    .start_pulse(start_pulse)
  );

  kwdt_stager #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u_stage (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pre_a(pre_a), .pre_b(pre_b),
    .cfg(cfg), .reload_pulse(reload_pulse), .clear_pulse(clear_pulse),
    .start_pulse(start_pulse), .cnt(cnt), .stage1_flag(stage1_flag),
    .rst_req(rst_req), .rst_warm(rst_warm), .tout_pin(tout_pin)
  );

  always_comb begin
    case (rd_addr)
      OFS_PRE_A: rdata = 32'(pre_a);
      OFS_PRE_B: rdata = 32'(pre_b);
      OFS_CFG:   rdata = 32'(cfg);
      OFS_CNT:   rdata = count_view(cnt);
      OFS_GUARD: rdata = {30'd0, enable, lock};
      default:   rdata = 32'd0;
    endcase
  end

  assert_start_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> $past(start_pulse));
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int PW = 8;
  localparam int SH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rdata;
  logic        stage1_flag, rst_req, rst_warm, tout_pin;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  keyed_wdt #(.PRE_W(PW), .SHIFT(SH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata), .stage1_flag(stage1_flag),
    .rst_req(rst_req), .rst_warm(rst_warm), .tout_pin(tout_pin)
  );

  always #5 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic keyed_wr(input logic [5:0] a, input logic [31:0] d);
    wr(6'h0C, 32'h80);
    wr(6'h0C, 32'h86);
    wr(a, d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int load_of(input int p, input int sc);
    return sc ? p * (1 << SH) + (1 << SH) - 1 : p;
  endfunction

  logic [31:0] v, held;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 flag", 32'(stage1_flag), 0);
    check("R1 rst_req", 32'(rst_req), 0);
    check("R1 tout", 32'(tout_pin), 0);
    foreach (held[i]) begin end
    rd(6'h00, v); check("R1 pre_a", v, 0);
    rd(6'h04, v); check("R1 pre_b", v, 0);
    rd(6'h10, v); check("R1 cfg", v, 0);
    rd(6'h14, v); check("R1 count", v, 0);
    rd(6'h18, v); check("R1 guard", v, 0);

    // sweep: R5 R6 R7 R8 R11
    for (int pa = 0; pa < 6; pa++) begin
      for (int pb = 0; pb < 4; pb++) begin
        for (int sc = 0; sc < 2; sc++) begin
          int ta, tb, cfgv;
          logic tog0;
          ta = (pa + 1) * (sc ? (1 << SH) : 1);
          tb = (pb + 1) * (sc ? (1 << SH) : 1);
          cfgv = (sc << 2) | ((pb & 1) << 3) | 16 | ((pa == 3) ? 32 : 0);
          wr(6'h18, 0);
          keyed_wr(6'h0D, 2);
          wr(6'h10, cfgv);
          keyed_wr(6'h00, pa);
          keyed_wr(6'h04, pb);
          check("R4 flag cleared", 32'(stage1_flag), 0);
          tog0 = tout_pin;
          wr(6'h18, 2);
          for (int n = 1; n <= ta + tb; n++) begin
            @(negedge clk);
            if (n == ta - 1) check("R6 flag before stage-one end", 32'(stage1_flag), 0);
            if (n == ta) begin
              check("R6 flag at stage-one end", 32'(stage1_flag), 1);
              rd(6'h14, v); check("R5 R11 stage-two load", v, load_of(pb, sc));
            end
            if (n < ta + tb) check("R7 no early request", 32'(rst_req), 0);
          end
          check("R7 request at stage-two end", 32'(rst_req), 1);
          check("R7 warm select", 32'(rst_warm), pb & 1);
          check("R8 pin toggle", 32'(tout_pin), 32'(tog0 ^ (pa != 3)));
          rd(6'h14, v); check("R7 restart stage one", v, load_of(pa, sc));
          @(negedge clk);
          check("R7 one-cycle request", 32'(rst_req), 0);
        end
      end
    end

    // R3 unguarded writes
    wr(6'h18, 0);
    keyed_wr(6'h00, 10);
    wr(6'h10, 32'h10);
    wr(6'h18, 2);
    wr(6'h0D, 1);
    rd(6'h14, v); check("R3 reload without key", v, 9);
    wr(6'h00, 32'h55);
    rd(6'h00, v); check("R3 preload without key", v, 10);
    wr(6'h0C, 32'h80); wr(6'h0C, 32'h85); wr(6'h00, 32'h33);
    rd(6'h00, v); check("R3 wrong second key", v, 10);
    wr(6'h0C, 32'h80); wr(6'h0C, 32'h86); wr(6'h10, 32'h18); wr(6'h00, 32'h33);
    rd(6'h00, v); check("R3 intervening write", v, 10);
    rd(6'h10, v); check("R3 intervening write applied", v, 32'h18);
    wr(6'h10, 32'h10);

    // R2 single use of unlock
    keyed_wr(6'h00, 32'h21);
    wr(6'h00, 32'h22);
    rd(6'h00, v); check("R2 one write per unlock", v, 32'h21);

    // R4 reload
    keyed_wr(6'h0D, 1);
    rd(6'h14, v); check("R4 reload value", v, 32'h21);
    idle(2);
    rd(6'h14, v); check("R4 counting after reload", v, 32'h1F);

    // R9 freeze and restart
    wr(6'h18, 0);
    rd(6'h14, held);
    idle(5);
    rd(6'h14, v); check("R9 frozen while disabled", v, held);
    wr(6'h18, 2);
    rd(6'h14, v); check("R9 enable loads stage one", v, 32'h21);
    wr(6'h18, 2);
    rd(6'h14, v); check("R9 re-enable no reload", v, 32'h20);

    // R12 reload on the stage-one expiry edge
    wr(6'h18, 0);
    keyed_wr(6'h00, 2);
    keyed_wr(6'h04, 5);
    keyed_wr(6'h0D, 2);
    wr(6'h18, 2);
    wr(6'h0C, 32'h80); wr(6'h0C, 32'h86); wr(6'h0D, 3);
    check("R12 set beats clear", 32'(stage1_flag), 1);
    rd(6'h14, v); check("R12 reload beats expiry", v, 2);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      check("R12 stays in stage one", 32'(rst_req), 0);
    end
    keyed_wr(6'h0D, 2);
    check("R4 flag clear", 32'(stage1_flag), 0);

    // R10 lock
    wr(6'h18, 3);
    wr(6'h18, 0);
    rd(6'h18, v); check("R10 lock keeps enable", v, 3);
    wr(6'h10, 32'h3C);
    rd(6'h10, v); check("R10 locked config", v, 32'h10);
    rd(6'h14, held);
    idle(1);
    rd(6'h14, v); check("R10 still counting", 32'(v != held), 1);

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(6'h18, v); check("R1 reset clears lock", v, 0);
    check("R1 pin after reset", 32'(tout_pin), 0);

    summary();
  end
endmodule